// File: doc/BRIEF.md
# SDRAM Bank-State Command Legality Monitor

This block watches the command pins of a single-data-rate SDRAM interface and keeps its own copy of the state of every bank. Each cycle it turns the clock-enable, chip-select, row-strobe, column-strobe and write-enable pins into one command. It then judges that command against the bank that the bank-select bits address, or against all banks for mode-register and refresh commands. A command that breaks the protocol raises `err_valid` in the same cycle, along with the command code, the bank and a reason code. The block never drives the memory.

Each bank has one down-counter. That counter times the row-to-column delay, the precharge time and the burst length, so the block can make the timed moves on its own: activating to open, burst to open, auto-precharge burst to precharging, and precharging to idle. A shared counter enforces the minimum spacing between activates to any two banks. Legal commands update the tracked state. Illegal commands, and commands in a cycle whose previous cycle had clock enable low, leave the state untouched.

Top module: `sdmon_top`

## Requirements
- R1: Decode with `cs_n` low, from {`ras_n`,`cas_n`,`we_n`}: 000 mode set (code 0), 001 refresh, 010 precharge (3), 011 activate (4), 100 write (5, or 7 with `a10` high), 101 read (6, or 8 with `a10` high), 110 burst stop (9), 111 no-op (10). `cs_n` high is deselect (11). A refresh reads as auto refresh (1) when `cke` is high and as self refresh (2) when `cke` is low. `err_cmd` carries this code.
- R2: After reset every bank is idle and no error is reported.
- R3: An activate to an idle bank starts row activation. For the next T_RCD-1 cycles, activate, read, write and precharge to that bank are illegal with reason 3. From T_RCD cycles after the activate, reads and writes are legal.
- R4: An activate issued fewer than T_RRD cycles after the previous accepted activate to any bank is illegal with reason 7.
- R5: A read or write to an idle bank is illegal with reason 5. An activate to a bank whose row is open, whether in a burst or not, is illegal with reason 6.
- R6: Reads, writes and precharges to an open bank are legal, including during a plain read or write burst.
- R7: A read or write with `a10` high starts a burst of BURST_LEN cycles. During that burst every command to the bank other than no-op and deselect is illegal with reason 2, burst stop included. When the burst ends, the bank precharges for T_RP cycles and then becomes idle.
- R8: A precharge to an open bank starts a precharge of T_RP cycles. During it, activate, read and write are illegal with reason 4, while precharge and burst stop are accepted and have no effect. An activate T_RP cycles after the precharge is legal.
- R9: Mode set and both refresh kinds are illegal with reason 1 unless every bank is idle.
- R10: A command is judged only by the state of the bank it addresses. Other banks' states do not matter.
- R11: When `cke` was low in the previous cycle, the command is neither checked nor applied.
- R12: An illegal command changes no state. The outputs `err_valid`, `err_cmd`, `err_bank` and `err_reason` are combinational and appear in the cycle the command is on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Address bit 10 (auto-precharge select) |
| err_valid | output | 1 | Current command is illegal |
| err_cmd | output | 4 | Decoded command code (R1) |
| err_bank | output | BA_W | Bank addressed by the command |
| err_reason | output | 3 | Reason code (R3 to R9) |

## Verification
A directed sequence puts each reason code exactly at its timing boundary: the cycle before and the cycle at which T_RCD, T_RRD, T_RP and the auto-precharge burst end. These cases separate off-by-one counter faults from wrong state choices. Interleaved commands to two banks show that a verdict follows the addressed bank alone. Clock-enable-low cycles show both that checking is suppressed and that a suppressed activate leaves the bank idle. A long seeded random mix of commands, banks and clock-enable values is then compared against a bench model of the requirements, reaching combinations such as refresh during bursts and overlapping precharges.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

    typedef enum logic [3:0] {
        CMD_MRS  = 4'd0,
        CMD_AREF = 4'd1,
        CMD_SREF = 4'd2,
        CMD_PRE  = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_WR   = 4'd5,
        CMD_RD   = 4'd6,
        CMD_WRA  = 4'd7,
        CMD_RDA  = 4'd8,
        CMD_BST  = 4'd9,
        CMD_NOP  = 4'd10,
        CMD_DES  = 4'd11
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE, BK_OPENING, BK_OPEN, BK_RD, BK_WR, BK_RDA, BK_WRA, BK_CLOSING
    } bank_st_e;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_NOT_IDLE = 3'd1,
        RSN_AP_LOCK  = 3'd2,
        RSN_TRCD     = 3'd3,
        RSN_TRP      = 3'd4,
        RSN_NO_ROW   = 3'd5,
        RSN_ROW_OPEN = 3'd6,
        RSN_TRRD     = 3'd7
    } reason_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } pins_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_bank_cmd(input cmd_e c);
        return c inside {CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_WRA, CMD_RDA, CMD_BST};
    endfunction

    function automatic logic is_global_cmd(input cmd_e c);
        return c inside {CMD_MRS, CMD_AREF, CMD_SREF};
    endfunction

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
    import sdmon_pkg::*;
(
    input  pins_t pins,
    output cmd_e  op
);
    always_comb begin
        op = CMD_NOP;
        if (pins.cs_n) begin
            op = CMD_DES;
        end else begin
            case ({pins.ras_n, pins.cas_n, pins.we_n})
                3'b000: op = CMD_MRS;
                3'b001: op = pins.cke ? CMD_AREF : CMD_SREF;
                3'b010: op = CMD_PRE;
                3'b011: op = CMD_ACT;
                3'b100: op = pins.a10 ? CMD_WRA : CMD_WR;
                3'b101: op = pins.a10 ? CMD_RDA : CMD_RD;
                3'b110: op = CMD_BST;
                default: op = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  cmd_e    op,
    input  logic    rrd_busy,
    input  logic    commit,
    output logic    idle,
    output reason_e reason
);
    localparam int MAX_T = max3(T_RCD, T_RP, BURST_LEN);
    localparam int CW    = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] BL_LD  = CW'(BURST_LEN - 1);

    bank_st_e st_q, st_d, eff;
    logic [CW-1:0] cnt_q, cnt_d;
    logic expired;

    assign expired = (cnt_q == '0);

    // State as seen in this cycle, with an expired timer already applied
    always_comb begin
        eff = st_q;
        if (expired) begin
            case (st_q)
                BK_OPENING, BK_RD, BK_WR: eff = BK_OPEN;
                BK_RDA, BK_WRA:           eff = BK_CLOSING;
                BK_CLOSING:               eff = BK_IDLE;
                default:                  eff = st_q;
            endcase
        end
    end

    assign idle = (eff == BK_IDLE);

    always_comb begin
        reason = RSN_NONE;
        case (eff)
            BK_IDLE: begin
                if (op inside {CMD_RD, CMD_WR, CMD_RDA, CMD_WRA}) reason = RSN_NO_ROW;
                else if (op == CMD_ACT && rrd_busy)                reason = RSN_TRRD;
            end
            BK_OPENING:
                if (op inside {CMD_PRE, CMD_ACT, CMD_RD, CMD_WR, CMD_RDA, CMD_WRA})
                    reason = RSN_TRCD;
            BK_OPEN, BK_RD, BK_WR:
                if (op == CMD_ACT) reason = RSN_ROW_OPEN;
            BK_RDA, BK_WRA:
                if (is_bank_cmd(op)) reason = RSN_AP_LOCK;
            BK_CLOSING:
                if (op inside {CMD_ACT, CMD_RD, CMD_WR, CMD_RDA, CMD_WRA})
                    reason = RSN_TRP;
            default: reason = RSN_NONE;
        endcase
    end

    always_comb begin
        st_d  = eff;
        cnt_d = expired ? cnt_q : cnt_q - 1'b1;
        if ((st_q == BK_RDA || st_q == BK_WRA) && expired) cnt_d = RP_LD;
        if (commit) begin
            case (op)
                CMD_ACT: begin st_d = BK_OPENING; cnt_d = RCD_LD; end
                CMD_RD:  begin st_d = BK_RD;      cnt_d = BL_LD;  end
                CMD_WR:  begin st_d = BK_WR;      cnt_d = BL_LD;  end
                CMD_RDA: begin st_d = BK_RDA;     cnt_d = BL_LD;  end
                CMD_WRA: begin st_d = BK_WRA;     cnt_d = BL_LD;  end
                CMD_PRE:
                    if (eff inside {BK_OPEN, BK_RD, BK_WR}) begin
                        st_d  = BK_CLOSING;
                        cnt_d = RP_LD;
                    end
                CMD_BST:
                    if (eff inside {BK_RD, BK_WR}) begin
                        st_d  = BK_OPEN;
                        cnt_d = '0;
                    end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R3: a row is only ever opened from activation or from a finished plain burst
    assert_open_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_OPEN && $past(st_q) != BK_OPEN) |->
            ($past(st_q) inside {BK_OPENING, BK_RD, BK_WR}))
        else $error("bank entered open from %0d", $past(st_q));

    // R7: an auto-precharge burst leaves only into precharging
    assert_ap_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) inside {BK_RDA, BK_WRA}) && !(st_q inside {BK_RDA, BK_WRA})) |->
            (st_q == BK_CLOSING))
        else $error("auto-precharge burst left to %0d", st_q);

    // R8: idle is reached only through precharging
    assert_idle_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_IDLE && $past(st_q) != BK_IDLE) |-> ($past(st_q) == BK_CLOSING))
        else $error("bank became idle from %0d", $past(st_q));

endmodule

// File: rtl/sdmon_top.sv
module sdmon_top
    import sdmon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            err_valid,
    output logic [3:0]      err_cmd,
    output logic [BA_W-1:0] err_bank,
    output logic [2:0]      err_reason
);
    localparam int RRD_W = $clog2(T_RRD + 1);
    localparam logic [RRD_W-1:0] RRD_LD = RRD_W'(T_RRD - 1);

    pins_t   pins;
    cmd_e    op;
    reason_e reason;
    reason_e bank_rsn [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_idle;
    logic    all_idle, cke_q, commit, rrd_busy;
    logic [RRD_W-1:0] rrd_cnt_q;

    assign pins = '{cke: cke, cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n, a10: a10};

    sdmon_decode i_decode (.pins(pins), .op(op));

    assign rrd_busy = (rrd_cnt_q != '0);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sdmon_bank #(
            .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
        ) i_bank (
            .clk     (clk),
            .rst     (rst),
            .op      (op),
            .rrd_busy(rrd_busy),
            .commit  (commit && (ba == BA_W'(i))),
            .idle    (bank_idle[i]),
            .reason  (bank_rsn[i])
        );
    end

    assign all_idle = &bank_idle;

    always_comb begin
        if (is_global_cmd(op)) reason = all_idle ? RSN_NONE : RSN_NOT_IDLE;
        else                   reason = bank_rsn[ba];
    end

    assign commit     = cke_q && (reason == RSN_NONE);
    assign err_valid  = cke_q && (reason != RSN_NONE);
    assign err_cmd    = op;
    assign err_bank   = ba;
    assign err_reason = reason;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q     <= 1'b1;
            rrd_cnt_q <= '0;
        end else begin
            cke_q <= cke;
            if (commit && op == CMD_ACT) rrd_cnt_q <= RRD_LD;
            else if (rrd_busy)           rrd_cnt_q <= rrd_cnt_q - 1'b1;
        end
    end

    // Checker state: cycles since the last accepted activate, saturating
    logic [RRD_W-1:0] gap_q;
    logic             seen_act_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q      <= '0;
            seen_act_q <= 1'b0;
        end else if (commit && op == CMD_ACT) begin
            gap_q      <= RRD_W'(1);
            seen_act_q <= 1'b1;
        end else if (gap_q < RRD_W'(T_RRD)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_rrd_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && op == CMD_ACT && seen_act_q) |-> (gap_q >= RRD_W'(T_RRD)))
        else $error("activates accepted %0d cycles apart", gap_q);

    assert_global_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && is_global_cmd(op)) |=> all_idle)
        else $error("mode set or refresh accepted with a busy bank");

    assert_cke_gate_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(cke) && !$past(rst)) |-> !err_valid)
        else $error("error raised after a clock-enable-low cycle");

endmodule

// File: tb/test_sdmon_top.sv
module test_sdmon_top;
    localparam int NB = 4, TRCD = 3, TRP = 3, TRRD = 2, BL = 4;
    localparam int S_IDLE = 0, S_OPENING = 1, S_OPEN = 2, S_RD = 3, S_WR = 4,
                   S_RDA = 5, S_WRA = 6, S_CLOSING = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = '0;
    logic err_valid;
    logic [3:0] err_cmd;
    logic [1:0] err_bank;
    logic [2:0] err_reason;

    int checks = 0, errs = 0;
    bit done = 1'b0;

    int mst [NB];
    int mcnt[NB];
    int mrrd;
    bit mckp;

    always #5 clk = ~clk;

    sdmon_top #(.NUM_BANKS(NB), .T_RCD(TRCD), .T_RP(TRP), .T_RRD(TRRD), .BURST_LEN(BL)) i_sdmon_top (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .err_valid(err_valid), .err_cmd(err_cmd),
        .err_bank(err_bank), .err_reason(err_reason));

    function automatic int eff(input int b);
        if (mcnt[b] == 0) begin
            if (mst[b] inside {S_OPENING, S_RD, S_WR}) return S_OPEN;
            if (mst[b] inside {S_RDA, S_WRA})          return S_CLOSING;
            if (mst[b] == S_CLOSING)                    return S_IDLE;
        end
        return mst[b];
    endfunction

    // Reason a command would get, from the requirements (R3..R9)
    function automatic int exp_reason(input int op, input int b);
        int e;
        if (op <= 2) begin
            for (int i = 0; i < NB; i++) if (eff(i) != S_IDLE) return 1;
            return 0;
        end
        e = eff(b);
        case (e)
            S_IDLE:    if (op >= 5 && op <= 8) return 5; else if (op == 4 && mrrd > 0) return 7;
            S_OPENING: if (op >= 3 && op <= 8) return 3;
            S_OPEN, S_RD, S_WR: if (op == 4) return 6;
            S_RDA, S_WRA: if (op >= 3 && op <= 9) return 2;
            S_CLOSING: if (op >= 4 && op <= 8) return 4;
            default: ;
        endcase
        return 0;
    endfunction

    function automatic string tag_of(input int r);
        case (r)
            1: return "R9";
            2: return "R7";
            3: return "R3";
            4: return "R8";
            5: return "R5";
            6: return "R5";
            7: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic model_update(input int op, input int b, input bit ck);
        int r, e[NB];
        bit com;
        r   = exp_reason(op, b);
        com = mckp && (r == 0);
        for (int i = 0; i < NB; i++) e[i] = eff(i);
        for (int i = 0; i < NB; i++) begin
            if ((mst[i] == S_RDA || mst[i] == S_WRA) && mcnt[i] == 0) begin
                mst[i] = S_CLOSING; mcnt[i] = TRP - 1;
            end else begin
                mst[i] = e[i];
                if (mcnt[i] > 0) mcnt[i]--;
            end
        end
        if (mrrd > 0) mrrd--;
        if (com) begin
            case (op)
                4: begin mst[b] = S_OPENING; mcnt[b] = TRCD - 1; mrrd = TRRD - 1; end
                5: begin mst[b] = S_WR;  mcnt[b] = BL - 1; end
                6: begin mst[b] = S_RD;  mcnt[b] = BL - 1; end
                7: begin mst[b] = S_WRA; mcnt[b] = BL - 1; end
                8: begin mst[b] = S_RDA; mcnt[b] = BL - 1; end
                3: if (e[b] inside {S_OPEN, S_RD, S_WR}) begin mst[b] = S_CLOSING; mcnt[b] = TRP - 1; end
                9: if (e[b] inside {S_RD, S_WR}) begin mst[b] = S_OPEN; mcnt[b] = 0; end
                default: ;
            endcase
        end
        mckp = ck;
    endtask

    // Pin encoding from R1
    task automatic drive(input int op, input int b, input bit ck);
        cke = ck; cs_n = 1'b0; ba = 2'(b); a10 = 1'b0;
        case (op)
            0: {ras_n, cas_n, we_n} = 3'b000;
            1, 2: {ras_n, cas_n, we_n} = 3'b001;
            3: {ras_n, cas_n, we_n} = 3'b010;
            4: {ras_n, cas_n, we_n} = 3'b011;
            5: {ras_n, cas_n, we_n} = 3'b100;
            6: {ras_n, cas_n, we_n} = 3'b101;
            7: begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b1; end
            8: begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b1; end
            9: {ras_n, cas_n, we_n} = 3'b110;
            11: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    endtask

    task automatic step(input int op, input int b, input bit ck, input int want, input string tag);
        int  exp;
        bit  ev;
        string t;
        @(negedge clk);
        drive(op, b, ck);
        #2;
        exp = (want >= 0) ? want : exp_reason(op, b);
        ev  = mckp && (exp != 0);
        t   = (tag != "") ? tag : tag_of(exp);
        checks++;
        if (err_valid !== ev ||
            (ev && (err_reason !== 3'(exp) || err_cmd !== 4'(op) || err_bank !== 2'(b)))) begin
            errs++;
            $display("FAIL %s op=%0d bank=%0d: actual valid=%0b reason=%0d cmd=%0d bank=%0d, expected valid=%0b reason=%0d cmd=%0d bank=%0d",
                     t, op, b, err_valid, err_reason, err_cmd, err_bank, ev, exp, op, b);
        end
        @(posedge clk);
        model_update(op, b, ck);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin mst[i] = S_IDLE; mcnt[i] = 0; end
        mrrd = 0; mckp = 1'b1;
        drive(10, 0, 1'b1);
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        step(10, 0, 1, 0, "R2");   // no error after reset
        step(6,  0, 1, 5, "R2");   // banks start idle
        step(0,  0, 1, 0, "R9");   // mode set with all idle
        step(4,  0, 1, 0, "R3");   // activate bank 0
        step(4,  1, 1, 7, "R4");   // one cycle later: too soon
        step(4,  1, 1, 0, "R4");   // exactly T_RRD later
        step(6,  1, 1, 3, "R3");   // row still activating
        step(3,  1, 1, 3, "R12");  // illegal precharge, must not apply
        step(5,  1, 1, 0, "R3");   // exactly T_RCD after activate
        step(8,  0, 1, 0, "R1");   // read with a10 -> auto precharge
        step(4,  0, 1, 2, "R7");
        step(9,  0, 1, 2, "R7");   // burst stop also locked out
        step(4,  1, 1, 6, "R5");   // row open on bank 1
        step(4,  0, 1, 4, "R7");   // burst over, precharging
        step(0,  0, 1, 1, "R9");
        step(5,  1, 1, 0, "R6");
        step(3,  1, 1, 0, "R6");   // precharge during write burst
        step(6,  1, 1, 4, "R8");
        step(3,  1, 1, 0, "R8");   // precharge while precharging: no-op
        step(4,  1, 1, 0, "R8");   // exactly T_RP after precharge
        step(6,  0, 1, 5, "R7");   // bank 0 back to idle
        step(6,  2, 1, 5, "R10");
        step(10, 0, 0, 0, "R11");
        step(4,  2, 0, 0, "R11");  // not applied
        step(6,  3, 1, 0, "R11");  // not checked
        step(6,  2, 1, 5, "R11");  // activate was ignored
        step(1,  0, 1, 1, "R9");
        step(2,  0, 0, 1, "R1");   // refresh with cke low is code 2
        step(10, 0, 1, 0, "R11");
        step(3,  1, 1, 0, "R8");
        step(10, 0, 1, 0, "R8");
        step(10, 0, 1, 0, "R8");
        step(1,  0, 1, 0, "R9");
        step(2,  0, 0, 0, "R9");
        step(10, 0, 1, 0, "R11");
        step(11, 0, 1, 0, "R1");

        void'($urandom(32'd2024));
        for (int n = 0; n < 2500; n++) begin
            int r, op, b;
            bit ck;
            r = $urandom_range(99, 0);
            if (r < 30) op = 10; else if (r < 34) op = 11; else if (r < 46) op = 4;
            else if (r < 56) op = 6; else if (r < 64) op = 5; else if (r < 69) op = 8;
            else if (r < 73) op = 7; else if (r < 83) op = 3; else if (r < 88) op = 9;
            else if (r < 90) op = 0; else if (r < 92) op = 1; else if (r < 93) op = 2;
            else op = 10;
            b  = $urandom_range(NB - 1, 0);
            ck = (op == 2) ? 1'b0 : (op == 1) ? 1'b1 : ($urandom_range(29, 0) != 0);
            step(op, b, ck, -1, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=still running, expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule